// File: doc/BRIEF.md
# Ethernet Port Status LED Event Controller

This block drives a single port status LED from the link state and the traffic activity of one Ethernet port. A small register write port programs an enable, the pin polarity, a mask of link conditions that light the LED steadily, a mask of activity sources and a force bit that make it blink, and the blink timing.

The blink timing is a period register and an on-time register. Both count units of a prescaler tick. The prescaler length is the module parameter `PRESCALE`. Setting the on-time to half the period gives an even duty cycle.

A blink-clear input restarts the blink generator, so several LEDs can be brought into phase. An activity pulse keeps the LED blinking for at least one full blink period. When no enabled blink source is active, the LED is steadily lit if any enabled link condition matches, and dark otherwise.

Top module: `led_event_ctrl`

## Requirements
- R1: After reset the control word is 0x4000 (disabled, active-high), both masks are 0, the period is 0x061A and the on-time is 0x030D. `led_out` reads 0.
- R2: While the enable bit (control bit 15) is 0, `led_out` is the inactive level, which is the inverse of the polarity bit, whatever the other inputs do.
- R3: Polarity bit 14 = 1 drives the lit state as 1 on `led_out`. Polarity 0 drives the lit state as 0.
- R4: Write addresses are 0 for control, 1 for the blink mask, 2 for the period and 3 for the on-time. Control bits 6:0 are the steady mask. A steady match is any of the following:
  - bit0 with link up at 1000M (`link_speed`=2)
  - bit1 with link up at 100M (=1)
  - bit2 with link up at 10M (=0)
  - bit3 with link down
  - bit4 with link up and full duplex
  - bit5 with link up and half duplex
  - bit6 (forced on)
  Speed code 3 matches no speed bit.
- R5: With enable set and no blink source active, `led_out` shows the steady match one clock edge after an input or register write edge.
- R6: While any blink source is active, the LED shows the blink waveform even if a steady condition matches.
- R7: Counting k clock edges after the edge that sampled `blink_clr`, the lit state shown after edge k (k≥1) is ((k-1) div PRESCALE) mod period < on-time. Period 0 or on-time 0 gives an always-dark waveform.
- R8: Asserting `blink_clr` in the middle of a running blink restarts the waveform at phase 0.
- R9: Blink mask bits enable the activity inputs as follows:
  - bit0: 1000M TX (`act_tx[0]`)
  - bit1: 1000M RX (`act_rx[0]`)
  - bit2: 100M TX (`act_tx[1]`)
  - bit3: 100M RX (`act_rx[1]`)
  - bit4: 10M TX (`act_tx[2]`)
  - bit5: 10M RX (`act_rx[2]`)
  An enabled pulse keeps blinking active from the next edge for at least (period-1)·PRESCALE edges. It ends within period·PRESCALE+1 edges.
- R10: An activity pulse whose mask bit is clear has no effect. Blink mask bit 9 keeps blinking active permanently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| link_up | input | 1 | Link is up |
| link_speed | input | 2 | 0=10M, 1=100M, 2=1000M |
| link_full | input | 1 | Full duplex when 1 |
| act_tx | input | 3 | TX activity pulses; index 0=1000M, 1=100M, 2=10M |
| act_rx | input | 3 | RX activity pulses, same indexing |
| blink_clr | input | 1 | Restart the blink generator |
| led_out | output | 1 | LED pin |

## Verification
The steady and disabled results are due one edge after the input change or register write. The bench drives on falling edges and samples at the following falling edge.

The blink waveform is due edge by edge after the clearing edge. The bench counts rising edges from that point and compares, 1 ns after each edge, against the R7 formula.

Activity hold is checked against the R9 bounds only: inside the guaranteed window, and again after the latest possible end. It is not checked at the exact falling edge, which depends on prescaler phase.

// File: rtl/led_evt_pkg.sv
package led_evt_pkg;
  localparam int CNT_W = 16;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_BLINK  = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;
  localparam logic [1:0] ADDR_ONTIME = 2'd3;

  localparam logic [1:0] SPD_10   = 2'd0;
  localparam logic [1:0] SPD_100  = 2'd1;
  localparam logic [1:0] SPD_1000 = 2'd2;

  localparam int BIT_EN        = 15;
  localparam int BIT_POL       = 14;
  localparam int BIT_FORCE_BLK = 9;

  typedef struct packed {
    logic             en;
    logic             pol;
    logic [6:0]       on_mask;
    logic [9:0]       blk_mask;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] on_time;
  } led_cfg_t;
endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_evt_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_PERIOD = 16'h061A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output led_cfg_t         cfg
);
  localparam logic [CNT_W-1:0] RST_ONTIME = RST_PERIOD >> 1;

  logic [CNT_W-1:0] ctrl_q, blk_q, per_q, ont_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CNT_W'(16'h4000);
      blk_q  <= '0;
      per_q  <= RST_PERIOD;
      ont_q  <= RST_ONTIME;
    end else if (we) begin
      case (addr)
        ADDR_CTRL:   ctrl_q <= wdata;
        ADDR_BLINK:  blk_q  <= wdata;
        ADDR_PERIOD: per_q  <= wdata;
        default:     ont_q  <= wdata;
      endcase
    end
  end

  always_comb begin
    cfg.en       = ctrl_q[BIT_EN];
    cfg.pol      = ctrl_q[BIT_POL];
    cfg.on_mask  = ctrl_q[6:0];
    cfg.blk_mask = blk_q[9:0];
    cfg.period   = per_q;
    cfg.on_time  = ont_q;
  end

  logic unused_bits;
  assign unused_bits = ^{ctrl_q[13:7], blk_q[CNT_W-1:10]};

  p_wr_ctrl_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $past(addr) == ADDR_CTRL) |-> ctrl_q == $past(wdata));
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int W        = 16,
  parameter int PRESCALE = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] period,
  input  logic [W-1:0] on_time,
  output logic         tick,
  output logic         wave
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_cnt;
  logic [W-1:0]  phase;
  logic          pre_wrap;

  assign pre_wrap = (pre_cnt == PRE_LAST);
  assign tick     = pre_wrap & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr)    pre_cnt <= '0;
    else if (pre_wrap) pre_cnt <= '0;
    else               pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (tick) begin
      if (phase >= period - 1'b1) phase <= '0;
      else                        phase <= phase + 1'b1;
    end
  end

  assign wave = (period != '0) && (phase < on_time);

  p_clear_restart_r8: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (phase == '0 && pre_cnt == '0));
  p_pre_bound_r7: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PRE_LAST);
endmodule

// File: rtl/led_event_eval.sv
module led_event_eval
  import led_evt_pkg::*;
#(
  parameter int NSPD = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  led_cfg_t        cfg,
  input  logic            link_up,
  input  logic [1:0]      link_speed,
  input  logic            link_full,
  input  logic [NSPD-1:0] act_tx,
  input  logic [NSPD-1:0] act_rx,
  input  logic            tick,
  output logic            on_match,
  output logic            blink_active
);
  logic [6:0]       cond;
  logic [NSPD-1:0]  hit_vec;
  logic             act_hit;
  logic [CNT_W-1:0] hold;

  always_comb begin
    cond[0] = link_up && link_speed == SPD_1000;
    cond[1] = link_up && link_speed == SPD_100;
    cond[2] = link_up && link_speed == SPD_10;
    cond[3] = !link_up;
    cond[4] = link_up && link_full;
    cond[5] = link_up && !link_full;
    cond[6] = 1'b1;
  end
  assign on_match = |(cond & cfg.on_mask);

  for (genvar i = 0; i < NSPD; i++) begin : g_act
    assign hit_vec[i] = (act_tx[i] & cfg.blk_mask[2*i]) |
                        (act_rx[i] & cfg.blk_mask[2*i+1]);
  end
  assign act_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst)                       hold <= '0;
    else if (act_hit)              hold <= cfg.period;
    else if (tick && hold != '0)   hold <= hold - 1'b1;
  end

  assign blink_active = cfg.blk_mask[BIT_FORCE_BLK] || (hold != '0);

  p_hold_load_r9: assert property (@(posedge clk) disable iff (rst)
    $past(act_hit) |-> hold == $past(cfg.period));
  p_hold_decay_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(hold) != '0 && !$past(act_hit) && !$past(tick)) |-> hold == $past(hold));
endmodule

// File: rtl/led_event_ctrl.sv
module led_event_ctrl
  import led_evt_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             link_up,
  input  logic [1:0]       link_speed,
  input  logic             link_full,
  input  logic [2:0]       act_tx,
  input  logic [2:0]       act_rx,
  input  logic             blink_clr,
  output logic             led_out
);
  led_cfg_t cfg;
  logic     tick, wave, on_match, blink_active, lit;

  led_cfg_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  led_blink_gen #(.W(CNT_W), .PRESCALE(PRESCALE)) u_blink (
    .clk(clk), .rst(rst), .clr(blink_clr), .period(cfg.period),
    .on_time(cfg.on_time), .tick(tick), .wave(wave)
  );

  led_event_eval #(.NSPD(3)) u_eval (
    .clk(clk), .rst(rst), .cfg(cfg), .link_up(link_up),
    .link_speed(link_speed), .link_full(link_full), .act_tx(act_tx),
    .act_rx(act_rx), .tick(tick), .on_match(on_match),
    .blink_active(blink_active)
  );

  assign lit = blink_active ? wave : on_match;

  always_ff @(posedge clk) begin
    if (rst)         led_out <= 1'b0;
    else if (cfg.en) led_out <= lit ~^ cfg.pol;
    else             led_out <= ~cfg.pol;
  end

  p_disabled_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg.en) |-> led_out == !$past(cfg.pol));
  p_blink_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg.en) && $past(blink_active)) |-> led_out == ($past(wave) ~^ $past(cfg.pol)));
endmodule

// File: tb/tb_led_event_ctrl.sv
module tb_led_event_ctrl;
  localparam int P = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic link_up = 1'b0, link_full = 1'b0, blink_clr = 1'b0;
  logic [1:0] link_speed = '0;
  logic [2:0] act_tx = '0, act_rx = '0;
  logic led_out;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  led_event_ctrl #(.PRESCALE(P)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .link_up(link_up), .link_speed(link_speed),
    .link_full(link_full), .act_tx(act_tx), .act_rx(act_rx),
    .blink_clr(blink_clr), .led_out(led_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: led_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic steady(input logic [6:0] m, input logic up,
                                  input logic [1:0] sp, input logic fd);
    logic r;
    r = m[6];
    if (up) begin
      r |= (m[0] && sp == 2) || (m[1] && sp == 1) || (m[2] && sp == 0);
      r |= (m[4] && fd) || (m[5] && !fd);
    end else r |= m[3];
    return r;
  endfunction

  task automatic clear_gen;
    @(negedge clk); blink_clr = 1'b1;
    @(negedge clk); blink_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset level", led_out, 1'b0);

    // R2: disabled, forced-on mask, both polarities
    for (int pl = 0; pl < 2; pl++) begin
      wr(2'd0, {1'b0, pl[0], 7'b0, 7'h7F});
      @(negedge clk);
      chk("R2 disabled idle", led_out, ~pl[0]);
    end

    // R3 R4 R5: exhaustive steady sweep
    for (int pl = 0; pl < 2; pl++)
      for (int st = 0; st < 16; st++)
        for (int m = 0; m < 128; m++) begin
          link_up = st[0]; link_full = st[1]; link_speed = st[3:2];
          wr(2'd0, {1'b1, pl[0], 7'b0, m[6:0]});
          @(negedge clk);
          chk("R4 R5 R3 steady match", led_out,
              steady(m[6:0], st[0], st[3:2], st[1]) ~^ pl[0]);
        end

    // R7 R6: blink waveform sweep with forced-on also set
    link_up = 1'b1; link_speed = 2'd2; link_full = 1'b1;
    for (int pl = 0; pl < 2; pl++)
      for (int per = 0; per < 6; per++)
        for (int d = 0; d <= per + 1; d++) begin
          wr(2'd0, {1'b1, pl[0], 7'b0, 7'h40});
          wr(2'd2, 16'(per));
          wr(2'd3, 16'(d));
          wr(2'd1, 16'h0200);
          clear_gen();
          for (int k = 1; k <= 2 * P * (per + 1); k++) begin
            @(posedge clk); #1;
            chk("R7 R6 blink waveform", led_out,
                ((per != 0) && ((((k - 1) / P) % (per == 0 ? 1 : per)) < d)) ~^ pl[0]);
          end
        end

    // R8: clear mid-run restarts at phase 0 (period 3, on-time 1)
    wr(2'd0, 16'h8000 | 16'h4000);
    wr(2'd2, 16'd3); wr(2'd3, 16'd1);
    repeat (6) @(negedge clk);
    clear_gen();
    for (int k = 1; k <= 3 * P; k++) begin
      @(posedge clk); #1;
      chk("R8 restart after clear", led_out, ((k - 1) / P) == 0);
    end

    // R9 R10: activity hold; steady mask empty, wave always lit
    wr(2'd1, 16'h0001);
    wr(2'd3, 16'd3);
    repeat (2) @(negedge clk);
    chk("R10 idle before activity", led_out, 1'b0);
    act_rx[0] = 1'b1;
    @(negedge clk); act_rx[0] = 1'b0;
    for (int k = 0; k < 3 * P + 4; k++) begin
      @(negedge clk);
      chk("R10 unmasked activity ignored", led_out, 1'b0);
    end
    act_tx[0] = 1'b1;
    @(negedge clk); act_tx[0] = 1'b0;
    for (int k = 1; k <= 3 * P + 2; k++) begin
      @(posedge clk); #1;
      if (k <= 2 * P) chk("R9 hold active", led_out, 1'b1);
      if (k == 3 * P + 2) chk("R9 hold expired", led_out, 1'b0);
    end

    // R10: force-blink bit alone keeps blinking
    wr(2'd1, 16'h0200);
    @(negedge clk);
    chk("R10 force blink lit", led_out, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule